// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external controller read and write a bank of eight command registers over a four-wire synchronous serial link. The wires are an active-low select, a serial clock, a data input, and a data output with a separate output-enable. The controller pulls select low on a falling clock edge and then runs a frame of exactly sixteen clock periods. The frame carries a direction flag, a three-bit register address, four dead periods and a data field. A write carries eight data bits. A read returns only the five low bits of the addressed register.

The whole block runs in the serial clock domain. Input bits are captured on rising edges. Read data is launched on falling edges, so the controller can sample it on the next rising edge. The output-enable is low at every moment that read data is not being shifted. An outside pad can therefore merge the data input and output onto one wire. That pad is not part of this block.

Top module: `sreg_slave`

## Requirements
- R1: A synchronous active-high reset clears all eight registers to zero and holds `sdo_oe` low.
- R2: The bit on `sdi` at the first rising edge after `cs_n` falls sets the direction: 1 means read and 0 means write. A read frame never changes any register, whatever `sdi` carries.
- R3: Rising edges 2, 3 and 4 capture the register address, least significant bit first.
- R4: The `sdi` values at rising edges 5 to 8 (the gap) have no effect.
- R5: In a write frame, rising edges 9 to 16 capture data bits 0 to 7, LSB first. The full byte is stored into the addressed register at edge 16.
- R6: In a read frame, `sdo_oe` rises on the falling edge that follows rising edge 8. Bit i (i = 0..4) of the addressed register is on `sdo` from the falling edge after rising edge 8+i until the next falling edge, so a controller samples it at rising edge 9+i.
- R7: `sdo_oe` is low in every other clock period of a read frame, in every period of a write frame, and while `cs_n` is high. `sdo` is 0 whenever `sdo_oe` is low.
- R8: If `cs_n` rises before the sixteenth rising edge, the frame is abandoned and no register changes.
- R9: While `cs_n` is high the bit counter is held at zero, so the next low period starts a fresh frame. Rising edges after the sixteenth, with `cs_n` still low, are ignored.
- R10: Read data covers bits 4:0 of the stored byte. Bits 7:5 are stored but never read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; the block's only clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data from the controller |
| sdo | output | 1 | Serial read data, LSB first |
| sdo_oe | output | 1 | High while `sdo` carries valid read data |

## Verification
Every register is first written with a distinct byte, with the gap bits set to all ones on odd addresses and all zeros on even ones. Reading all of them back separates address decoding faults and bit-order faults from gap-bit leakage. One register is then swept through all 256 byte values while the controller drives the inverted byte on `sdi` during each read. This shows whether the upper three bits ever reach the output, and whether a read ever writes. Frames cut short at several edge counts, and frames run past sixteen clocks, show that commits happen only on the sixteenth edge and that the output window opens and closes on the right falling edges.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  // Kind of bit carried by the rising edge that is currently due.
  typedef enum logic [2:0] {
    PH_OFF,
    PH_DIR,
    PH_ADDR,
    PH_GAP,
    PH_DATA
  } phase_e;

  // Edge count of one complete frame.
  function automatic int frame_len(input int addr_w, input int gap_w, input int wr_w);
    return 1 + addr_w + gap_w + wr_w;
  endfunction

endpackage

// File: rtl/sreg_frame_ctr.sv
module sreg_frame_ctr #(
  parameter int ADDR_W = 3,
  parameter int GAP_W  = 4,
  parameter int WR_W   = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sdi,
  output logic [CNT_W-1:0]  cnt,
  output logic              rw,
  output logic [ADDR_W-1:0] addr,
  output logic              wr_en,
  output logic [WR_W-1:0]   wr_data
);
  import sreg_pkg::*;

  localparam int HDR_END    = 1 + ADDR_W;
  localparam int DATA_START = HDR_END + GAP_W;
  localparam int FRAME      = DATA_START + WR_W;
  localparam logic [CNT_W-1:0] C_HDR   = CNT_W'(HDR_END);
  localparam logic [CNT_W-1:0] C_START = CNT_W'(DATA_START);
  localparam logic [CNT_W-1:0] C_FRAME = CNT_W'(FRAME);
  localparam logic [CNT_W-1:0] C_LAST  = CNT_W'(FRAME - 1);

  phase_e          phase;
  logic [WR_W-2:0] wsh;

  // The phase depends on how many rising edges the frame has seen so far.
  always_comb begin
    if (cs_n || cnt >= C_FRAME) phase = PH_OFF;
    else if (cnt == '0)         phase = PH_DIR;
    else if (cnt < C_HDR)       phase = PH_ADDR;
    else if (cnt < C_START)     phase = PH_GAP;
    else                        phase = PH_DATA;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      rw   <= 1'b0;
      addr <= '0;
      wsh  <= '0;
    end else if (cs_n) begin
      cnt <= '0;
    end else begin
      if (cnt != C_FRAME) cnt <= cnt + 1'b1;
      case (phase)
        PH_DIR:  rw   <= sdi;
        PH_ADDR: addr <= {sdi, addr[ADDR_W-1:1]};
        PH_DATA: wsh  <= {sdi, wsh[WR_W-2:1]};
        default: ;
      endcase
    end
  end

  // The commit happens only on the last edge of a write frame that ran to the end.
  assign wr_en   = (phase == PH_DATA) && (cnt == C_LAST) && !rw;
  assign wr_data = {sdi, wsh};

  assert_cnt_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n) |-> (cnt == '0));

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (rst)
    cnt <= C_FRAME);

  assert_write_at_end_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (cnt == C_FRAME));

endmodule

// File: rtl/sreg_regbank.sv
module sreg_regbank #(
  parameter int ADDR_W = 3,
  parameter int WR_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WR_W-1:0]   wr_data,
  output logic [WR_W-1:0]   rd_q
);
  localparam int NREG = 1 << ADDR_W;

  logic [WR_W-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
      rd_q <= '0;
    end else begin
      if (wr_en) mem[addr] <= wr_data;
      rd_q <= mem[addr];
    end
  end

  assert_no_write_in_reset_R1: assert property (@(posedge clk)
    rst |-> !wr_en);

endmodule

// File: rtl/sreg_sdo_drv.sv
module sreg_sdo_drv #(
  parameter int WR_W       = 8,
  parameter int RD_W       = 5,
  parameter int DATA_START = 8,
  parameter int CNT_W      = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             rw,
  input  logic [CNT_W-1:0] cnt,
  input  logic [WR_W-1:0]  rd_q,
  output logic             sdo,
  output logic             sdo_oe
);
  localparam logic [CNT_W-1:0] C_START = CNT_W'(DATA_START);
  localparam logic [CNT_W-1:0] C_END   = CNT_W'(DATA_START + RD_W);

  logic [WR_W-1:0] sh;

  // Launches on falling edges, half a period ahead of the controller's sample.
  always_ff @(negedge clk) begin
    if (rst || cs_n) begin
      sdo_oe <= 1'b0;
      sh     <= '0;
    end else if (rw && cnt == C_START) begin
      sdo_oe <= 1'b1;
      sh     <= rd_q;
    end else if (sdo_oe && cnt < C_END) begin
      sh <= {1'b0, sh[WR_W-1:1]};
    end else begin
      sdo_oe <= 1'b0;
      sh     <= '0;
    end
  end

  assign sdo = sh[0];

  assert_oe_window_R7: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> (rw && cnt >= C_START && cnt < C_END));

  assert_oe_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> !sdo_oe);

endmodule

// File: rtl/sreg_slave.sv
module sreg_slave #(
  parameter int ADDR_W = 3,
  parameter int GAP_W  = 4,
  parameter int WR_W   = 8,
  parameter int RD_W   = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe
);
  localparam int FRAME      = sreg_pkg::frame_len(ADDR_W, GAP_W, WR_W);
  localparam int DATA_START = 1 + ADDR_W + GAP_W;
  localparam int CNT_W      = $clog2(FRAME + 1);

  logic [CNT_W-1:0]  cnt;
  logic              rw;
  logic [ADDR_W-1:0] addr;
  logic              wr_en;
  logic [WR_W-1:0]   wr_data;
  logic [WR_W-1:0]   rd_q;

  sreg_frame_ctr #(
    .ADDR_W(ADDR_W), .GAP_W(GAP_W), .WR_W(WR_W), .CNT_W(CNT_W)
  ) u_ctr (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sdi(sdi),
    .cnt(cnt), .rw(rw), .addr(addr), .wr_en(wr_en), .wr_data(wr_data)
  );

  sreg_regbank #(
    .ADDR_W(ADDR_W), .WR_W(WR_W)
  ) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_q(rd_q)
  );

  sreg_sdo_drv #(
    .WR_W(WR_W), .RD_W(RD_W), .DATA_START(DATA_START), .CNT_W(CNT_W)
  ) u_drv (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rw(rw), .cnt(cnt),
    .rd_q(rd_q), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  assert_abort_no_write_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !cs_n);

endmodule

// File: tb/sreg_slave_bench.sv
module sreg_slave_bench;
  logic clk = 1'b0;
  logic rst, cs_n, sdi;
  logic sdo, sdo_oe;
  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  sreg_slave u_sreg_slave (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs one frame of nclk rising edges. The order on sdi is dir, addr LSB first,
  // gap, then data LSB first. Returns the five read bits and the number of
  // periods whose output enable was wrong.
  task automatic frame(input logic rw, input logic [2:0] a, input logic [3:0] gap,
                       input logic [7:0] d, input int nclk,
                       output logic [4:0] got, output int win_err);
    logic [15:0] bits;
    logic        exp_oe;
    bits = {d, gap, a, rw};
    got = '0;
    win_err = 0;
    for (int k = 1; k <= nclk; k++) begin
      @(negedge clk); #1;
      if (k == 1) cs_n = 1'b0;
      sdi = (k <= 16) ? bits[k-1] : 1'b1;
      #5;
      exp_oe = rw && (k >= 9) && (k <= 13);
      if (sdo_oe !== exp_oe) win_err++;
      if (!sdo_oe && sdo !== 1'b0) win_err++;
      if (exp_oe) got[k-9] = sdo;
    end
    @(negedge clk); #1;
    cs_n = 1'b1;
    sdi = 1'b0;
    @(negedge clk); #6;
    if (sdo_oe !== 1'b0) win_err++;
    repeat (12) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 53 + 156) & 255);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [4:0] got;
    int we;
    rst = 1'b1; cs_n = 1'b1; sdi = 1'b0;
    repeat (3) @(negedge clk);
    #2 rst = 1'b0;
    @(negedge clk); #6;
    chk("R1 oe after reset", 32'(sdo_oe), 0);

    // R1: every register reads zero after reset
    for (int a = 0; a < 8; a++) begin
      frame(1'b1, 3'(a), 4'h0, 8'h00, 16, got, we);
      chk("R1 reset contents", 32'(got), 0);
      chk("R6 read window", 32'(we), 0);
    end

    // R3 R4 R5: distinct bytes, gap bits all ones on odd addresses
    for (int a = 0; a < 8; a++) begin
      frame(1'b0, 3'(a), (a % 2 == 1) ? 4'hF : 4'h0, pat(a), 16, got, we);
      chk("R7 oe low in write frame", 32'(we), 0);
    end
    for (int a = 0; a < 8; a++) begin
      frame(1'b1, 3'(a), (a % 2 == 0) ? 4'hF : 4'h0, 8'h00, 16, got, we);
      chk("R3 R5 readback", 32'(got), 32'(pat(a) & 8'h1F));
      chk("R6 read window", 32'(we), 0);
    end

    // R10 R2: sweep register 5 through all bytes; sdi carries ~v during the read
    for (int v = 0; v < 256; v++) begin
      frame(1'b0, 3'd5, 4'h5, 8'(v), 16, got, we);
      frame(1'b1, 3'd5, 4'hA, ~8'(v), 16, got, we);
      chk("R10 low five bits", 32'(got), 32'(v & 31));
      if (we != 0) chk("R6 sweep window", 32'(we), 0);
    end
    frame(1'b1, 3'd4, 4'h0, 8'h00, 16, got, we);
    chk("R3 neighbour 4 untouched", 32'(got), 32'(pat(4) & 8'h1F));
    frame(1'b1, 3'd6, 4'h0, 8'h00, 16, got, we);
    chk("R3 neighbour 6 untouched", 32'(got), 32'(pat(6) & 8'h1F));

    // R2: a read with sdi held high does not write
    frame(1'b1, 3'd0, 4'hF, 8'hFF, 16, got, we);
    frame(1'b1, 3'd0, 4'h0, 8'h00, 16, got, we);
    chk("R2 read leaves register", 32'(got), 32'(pat(0) & 8'h1F));

    // R8: aborted writes after 15 edges and after 3 edges
    frame(1'b0, 3'd2, 4'h0, 8'h55, 15, got, we);
    frame(1'b0, 3'd2, 4'h0, 8'h4A, 3, got, we);
    frame(1'b1, 3'd2, 4'h0, 8'h00, 16, got, we);
    chk("R8 abort keeps value", 32'(got), 32'(pat(2) & 8'h1F));

    // R9: extra edges after the frame are ignored; a cut read, then a clean read
    frame(1'b0, 3'd3, 4'h0, 8'h0A, 20, got, we);
    chk("R7 oe low in long write", 32'(we), 0);
    frame(1'b1, 3'd3, 4'h0, 8'h00, 20, got, we);
    chk("R9 extra edges ignored", 32'(got), 32'h0A);
    chk("R7 oe low after window", 32'(we), 0);
    frame(1'b1, 3'd7, 4'h0, 8'h00, 10, got, we);
    chk("R7 oe released on abort", 32'(we), 0);
    frame(1'b1, 3'd7, 4'h0, 8'h00, 16, got, we);
    chk("R9 fresh frame after abort", 32'(got), 32'(pat(7) & 8'h1F));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule